// File: doc/BRIEF.md
# Turbo Decoder Pass Sequencer

This block drives the address side of an iterative turbo decoder over one stored block of soft symbols. Once a block length and an iteration count have been latched, a start pulse makes it step through every symbol position twice per iteration. The first pass of each iteration uses natural order and the first parity stream. The second pass uses permuted order and the second (interleaved) parity stream. Each step presents one read address. That address feeds the symbol/parity store and the extrinsic store alike, so both memories see the same order in both passes.

The permuted order comes from a small table that software loads while the block is idle. The table reorders positions inside each aligned group of 64 symbols and leaves the group index unchanged. Window-start and pass-end strobes frame the work for the arithmetic that follows. A single-cycle completion pulse marks the end of the final pass.

Top module: `turbo_pass_sequencer`

## Requirements
- R1: After reset `busy`, `step_vld`, `done`, `win_start` and `half_end` are all 0.
- R2: When `cfg_set` is high while idle, the length is latched clamped to [40, 5114] and the iteration count is latched with 0 replaced by 1. A run makes exactly 2 × length × count steps.
- R3: While `half_even` is 0 (first pass, first parity stream), step k presents `rd_addr` = k for k = 0 … length−1.
- R4: While `half_even` is 1 (second pass, interleaved parity stream), step k presents `rd_addr` = {k[12:6], T[k[5:0]]}, where T is the 64-entry table. If that value is ≥ length, `rd_addr` = k instead.
- R5: A run starts with the natural pass at address 0. The passes alternate natural then permuted, with no idle cycle between them, and repeat once per iteration.
- R6: `win_start` is 1 exactly on steps whose index k is a multiple of the window size (16 by default).
- R7: `half_end` is 1 exactly on step length−1 of each pass, including when the last window is shorter than the window size.
- R8: `done` is high for one cycle, in the cycle after the last permuted-pass step of the final iteration. `busy` is low in that same cycle.
- R9: `sync_clr` ends any run at the next edge without a `done` pulse. The latched configuration and the table are kept.
- R10: While busy, `start`, `cfg_set` and `tbl_we` have no effect on the run in progress or on later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous abandon of the current run |
| cfg_set | input | 1 | Latch `cfg_len` and `cfg_iter` (idle only) |
| cfg_len | input | 13 | Block length in symbols |
| cfg_iter | input | 4 | Iteration count, 1 to 15 (0 read as 1) |
| start | input | 1 | Begin a run (idle only) |
| tbl_we | input | 1 | Permutation table write enable (idle only) |
| tbl_addr | input | 6 | Table entry index |
| tbl_data | input | 6 | Table entry value |
| busy | output | 1 | Run in progress |
| step_vld | output | 1 | `rd_addr` holds a valid step |
| half_even | output | 1 | 0 natural pass / first parity, 1 permuted pass / second parity |
| rd_addr | output | 13 | Read address for symbol/parity and extrinsic stores |
| win_start | output | 1 | First step of a window |
| half_end | output | 1 | Last step of a pass |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A random permutation is loaded and random lengths from 40 to 300 are run with one to three iterations. Every step is compared with an address computed in the bench. This separates a correct group-wise permutation from a natural-order or shifted one, and it catches a pass order that starts wrong or a missing alternation. Directed runs use a length of exactly 64, which gives whole windows and a whole group. They also use length 100, whose tail group folds out-of-range entries back to natural order. Lengths of 20 and 8000 and a count of 0 check the clamping through the step count. Further runs clear the block in the middle of a run and drive start, configuration and table writes during a run, then show that the current and the following runs are unchanged.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    PASS_NAT  = 1'b0,
    PASS_PERM = 1'b1
  } pass_e;
endpackage

// File: rtl/tps_cfg.sv
module tps_cfg #(
  parameter int LEN_W   = 13,
  parameter int IT_W    = 4,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 5114
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [LEN_W-1:0] len_in,
  input  logic [IT_W-1:0]  iter_in,
  output logic [LEN_W-1:0] len_q,
  output logic [IT_W-1:0]  iter_q
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] len_fix, len_d;
  logic [IT_W-1:0]  iter_fix, iter_d;

  always_comb begin
    if (len_in < LO)      len_fix = LO;
    else if (len_in > HI) len_fix = HI;
    else                  len_fix = len_in;
    iter_fix = (iter_in == '0) ? IT_W'(1) : iter_in;
    len_d    = ld ? len_fix  : len_q;
    iter_d   = ld ? iter_fix : iter_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LO;
      iter_q <= IT_W'(1);
    end else begin
      len_q  <= len_d;
      iter_q <= iter_d;
    end
  end
endmodule

// File: rtl/tps_perm_table.sv
module tps_perm_table #(
  parameter int LEN_W  = 13,
  parameter int TBL_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TBL_AW-1:0] waddr,
  input  logic [TBL_AW-1:0] wdata,
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  perm_addr
);
  localparam int DEPTH = 1 << TBL_AW;

  logic [TBL_AW-1:0] mem [DEPTH];
  logic [LEN_W-1:0]  cand;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    cand      = {idx[LEN_W-1:TBL_AW], mem[idx[TBL_AW-1:0]]};
    perm_addr = (cand >= len) ? idx : cand;
  end
endmodule

// File: rtl/tps_walker.sv
module tps_walker
  import tps_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int IT_W    = 4,
  parameter int WIN_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [IT_W-1:0]  iters,
  output logic             run,
  output logic [LEN_W-1:0] idx,
  output pass_e            pass,
  output logic             win_start,
  output logic             half_end,
  output logic             done
);
  logic             run_d, done_d;
  logic [LEN_W-1:0] idx_d;
  pass_e            pass_d;
  logic [IT_W-1:0]  it_q, it_d;

  assign half_end  = run && (idx == len - LEN_W'(1));
  assign win_start = run && (idx[WIN_LOG-1:0] == '0);

  always_comb begin
    run_d  = run;
    idx_d  = idx;
    pass_d = pass;
    it_d   = it_q;
    done_d = 1'b0;
    if (sync_clr) begin
      run_d  = 1'b0;
      idx_d  = '0;
      pass_d = PASS_NAT;
      it_d   = '0;
    end else if (!run) begin
      if (start) begin
        run_d  = 1'b1;
        idx_d  = '0;
        pass_d = PASS_NAT;
        it_d   = '0;
      end
    end else if (half_end) begin
      idx_d = '0;
      if (pass == PASS_PERM) begin
        pass_d = PASS_NAT;
        if (it_q == iters - IT_W'(1)) begin
          run_d  = 1'b0;
          done_d = 1'b1;
          it_d   = '0;
        end else begin
          it_d = it_q + IT_W'(1);
        end
      end else begin
        pass_d = PASS_PERM;
      end
    end else begin
      idx_d = idx + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      idx  <= '0;
      pass <= PASS_NAT;
      it_q <= '0;
      done <= 1'b0;
    end else begin
      run  <= run_d;
      idx  <= idx_d;
      pass <= pass_d;
      it_q <= it_d;
      done <= done_d;
    end
  end
endmodule

// File: rtl/turbo_pass_sequencer.sv
module turbo_pass_sequencer
  import tps_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int IT_W    = 4,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 5114,
  parameter int WIN     = 16,
  parameter int TBL_AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              cfg_set,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [IT_W-1:0]   cfg_iter,
  input  logic              start,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic [TBL_AW-1:0] tbl_data,
  output logic              busy,
  output logic              step_vld,
  output logic              half_even,
  output logic [LEN_W-1:0]  rd_addr,
  output logic              win_start,
  output logic              half_end,
  output logic              done
);
  localparam int WIN_LOG = $clog2(WIN);

  logic [LEN_W-1:0] len_q, idx, perm_addr;
  logic [IT_W-1:0]  iter_q;
  logic             run;
  pass_e            pass;

  tps_cfg #(.LEN_W(LEN_W), .IT_W(IT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld(cfg_set && !run),
    .len_in(cfg_len), .iter_in(cfg_iter), .len_q(len_q), .iter_q(iter_q)
  );

  tps_perm_table #(.LEN_W(LEN_W), .TBL_AW(TBL_AW)) u_tbl (
    .clk(clk), .we(tbl_we && !run), .waddr(tbl_addr), .wdata(tbl_data),
    .idx(idx), .len(len_q), .perm_addr(perm_addr)
  );

  tps_walker #(.LEN_W(LEN_W), .IT_W(IT_W), .WIN_LOG(WIN_LOG)) u_walk (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .start(start),
    .len(len_q), .iters(iter_q), .run(run), .idx(idx), .pass(pass),
    .win_start(win_start), .half_end(half_end), .done(done)
  );

  assign busy      = run;
  assign step_vld  = run;
  assign half_even = (pass == PASS_PERM);
  assign rd_addr   = (pass == PASS_PERM) ? perm_addr : idx;
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_clr,
  input logic             busy,
  input logic             step_vld,
  input logic             half_even,
  input logic [LEN_W-1:0] rd_addr,
  input logic             win_start,
  input logic             half_end,
  input logic             done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy && half_even && half_end)); // R8
  AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !busy && !done); // R9
  AST_RUN_BEGINS_NAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !half_even && rd_addr == '0 && win_start); // R5
  AST_PASS_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_end && !sync_clr) |=> !busy || (half_even != $past(half_even))); // R5
  AST_NAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_vld && !half_even && !half_end && !sync_clr) |=>
      step_vld && !half_even && rd_addr == $past(rd_addr) + LEN_W'(1)); // R3
  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start || half_end) |-> step_vld); // R6
endmodule

bind turbo_pass_sequencer tps_checker #(.LEN_W(LEN_W)) u_tps_chk (
  .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .busy(busy),
  .step_vld(step_vld), .half_even(half_even), .rd_addr(rd_addr),
  .win_start(win_start), .half_end(half_end), .done(done)
);

// File: tb/turbo_pass_sequencer_bench.sv
module turbo_pass_sequencer_bench;
  localparam int LW = 13;
  localparam int WINB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_clr = 1'b0, cfg_set = 1'b0, start = 1'b0, tbl_we = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [3:0] cfg_iter = '0;
  logic [5:0] tbl_addr = '0, tbl_data = '0;
  logic busy, step_vld, half_even, win_start, half_end, done;
  logic [LW-1:0] rd_addr;

  int n_chk = 0;
  int n_fail = 0;
  int tbl [64];

  always #4 clk = ~clk;

  turbo_pass_sequencer u_turbo_pass_sequencer (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cfg_set(cfg_set),
    .cfg_len(cfg_len), .cfg_iter(cfg_iter), .start(start), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .busy(busy), .step_vld(step_vld),
    .half_even(half_even), .rd_addr(rd_addr), .win_start(win_start),
    .half_end(half_end), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp_len(input int l);
    if (l < 40) return 40;
    if (l > 5114) return 5114;
    return l;
  endfunction

  function automatic int exp_addr(input int i, input bit ev, input int l);
    int p;
    if (!ev) return i;
    p = (i & ~63) | tbl[i & 63];
    return (p >= l) ? i : p;
  endfunction

  task automatic set_cfg(input int l, input int it);
    @(negedge clk);
    cfg_set = 1'b1; cfg_len = LW'(l); cfg_iter = 4'(it);
    @(negedge clk);
    cfg_set = 1'b0;
  endtask

  task automatic load_table();
    for (int i = 0; i < 64; i++) tbl[i] = i;
    for (int i = 63; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0));
      t = tbl[i]; tbl[i] = tbl[j]; tbl[j] = t;
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(i); tbl_data = 6'(tbl[i]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // inj=1 drives start, cfg_set and table writes during the run (R10)
  task automatic run_block(input int l, input int it, input int inj, input string req_len);
    int bad;
    bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < it; k++) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < l; i++) begin
          int ea;
          ea = exp_addr(i, h[0], l);
          if (!(step_vld && busy)) begin bad++; chk(0, req_len, int'(step_vld), 1); end
          if (half_even !== h[0]) begin bad++; chk(0, "R5", int'(half_even), h); end
          if (int'(rd_addr) != ea) begin bad++; chk(0, h ? "R4" : "R3", int'(rd_addr), ea); end
          if (win_start !== ((i % WINB) == 0)) begin bad++; chk(0, "R6", int'(win_start), int'((i % WINB) == 0)); end
          if (half_end !== (i == l - 1)) begin bad++; chk(0, "R7", int'(half_end), int'(i == l - 1)); end
          if (done !== 1'b0) begin bad++; chk(0, "R8", int'(done), 0); end
          if (inj == 1 && k == 0 && h == 0 && i == 3) begin
            start = 1'b1; cfg_set = 1'b1; cfg_len = LW'(45); cfg_iter = 4'd9;
            tbl_we = 1'b1; tbl_addr = 6'd7; tbl_data = 6'(~tbl[7]);
          end
          if (inj == 1 && k == 0 && h == 0 && i == 4) begin
            start = 1'b0; cfg_set = 1'b0; tbl_we = 1'b0;
          end
          @(negedge clk);
        end
      end
    end
    chk(bad == 0, "R3 R4 step trace", bad, 0);
    chk(busy == 1'b0, req_len, int'(busy), 0);
    chk(done == 1'b1, "R8", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !step_vld && !done && !win_start && !half_end, "R1",
        int'({busy, step_vld, done, win_start, half_end}), 0);

    load_table();

    // whole windows and one whole group
    set_cfg(64, 2);
    run_block(64, 2, 0, "R5");
    // partial tail group and short last window
    set_cfg(100, 1);
    run_block(100, 1, 0, "R7");
    // clamping
    set_cfg(20, 1);
    run_block(clamp_len(20), 1, 0, "R2");
    set_cfg(8000, 0);
    run_block(clamp_len(8000), 1, 0, "R2");

    // mid-run disturbances, then a follow-up run with the same settings
    set_cfg(70, 2);
    run_block(70, 2, 1, "R10");
    run_block(70, 2, 0, "R10");

    // synchronous abandon
    set_cfg(80, 2);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    chk(!busy && !step_vld && !done, "R9", int'({busy, step_vld, done}), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!done && !busy, "R9", int'({done, busy}), 0);
    end
    run_block(80, 2, 0, "R9");

    // random lengths, counts and tables
    for (int r = 0; r < 6; r++) begin
      int l, it;
      load_table();
      l  = int'($urandom_range(300, 40));
      it = int'($urandom_range(3, 1));
      set_cfg(l, it);
      run_block(l, it, 0, "R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule